// File: doc/BRIEF.md
# ISDN B-Channel Slot Port

This block moves one 8-bit voice sample per frame into, and one out of, a single B channel of a 2B+D serial frame. A shared bit clock and a frame sync arrive as levels that are synchronous to the core clock. The block detects their edges and counts bit-clock rising edges from the start of each frame. A mode strap chooses between two slot timings:
- a double-rate timing, in which each bit lasts two bit clocks and each channel lasts sixteen;
- a single-rate timing with offset slots, in which each bit lasts one bit clock.

A channel strap chooses which of the two B slots is used. It applies to both directions.

The transmit side drives a serial data bit and a separate output enable, which a pad ring turns into a three-state pin. The receive side samples the serial input, assembles the byte MSB first and presents it with a one-cycle strobe. The mode strap counts only when two frames in a row agree on it. Until then the transmit side stays in high impedance and no byte is received.

Top module: `isdn_bslot_port`

## Requirements
- R1: While reset is asserted and directly after it, `tx_oe_o`, `tx_data_o` and `rx_valid_o` are 0 and `rx_byte_o` is 0.
- R2: A frame starts at a bit-clock rising edge where `fsync_i` is sampled 1, provided it was sampled 0 at the previous rising edge. At each frame start the mode strap is sampled (0 = double-rate mode, 1 = single-rate mode). The frame uses that mode only if the sample equals the one taken at the previous frame start. Otherwise `tx_oe_o` stays 0 for the whole frame and `rx_valid_o` does not pulse.
- R3: The channel strap is sampled at each frame start (0 = first B slot, 1 = second B slot). It selects the slot for both transmit and receive.
- R4: Number the bit-clock rising edges of a frame from 0 at the frame start. In double-rate mode the slot covers rising edges 0 to 15 for the first channel and 16 to 31 for the second. Bit i (MSB first) is driven from rising edge base+2i. `tx_oe_o` rises at rising edge base and falls at the falling edge that follows rising edge base+15.
- R5: In double-rate mode, received bit i is sampled at rising edge base+2i+1.
- R6: In single-rate mode the slot covers rising edges 1 to 8 for the first channel and 11 to 18 for the second. Bit i is driven from rising edge base+i. `tx_oe_o` falls at the falling edge that follows rising edge base+7.
- R7: In single-rate mode, received bit i is sampled at the falling edge that follows rising edge base+i.
- R8: Outside the selected slot `tx_oe_o` is 0, and `tx_data_o` is 0 whenever `tx_oe_o` is 0. `tx_oe_o` changes only in response to a bit-clock edge.
- R9: After the eighth received bit of the selected slot, `rx_valid_o` is high for exactly one core-clock cycle, and `rx_byte_o` then holds the byte (first received bit in bit 7).
- R10: `tx_byte_i` is captured at the frame start. Changes to it later in the frame do not affect the bits sent in that frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bclk_i | input | 1 | Bit clock level, synchronous to `clk` |
| fsync_i | input | 1 | Frame sync level, synchronous to `clk` |
| mode_strap_i | input | 1 | 0 = double-rate slot timing, 1 = single-rate offset timing |
| chan_strap_i | input | 1 | 0 = first B slot, 1 = second B slot |
| tx_byte_i | input | 8 | Byte to send in the next frame |
| rx_data_i | input | 1 | Serial receive data |
| tx_data_o | output | 1 | Serial transmit data |
| tx_oe_o | output | 1 | Transmit enable; 0 means high impedance |
| rx_byte_o | output | 8 | Last byte received |
| rx_valid_o | output | 1 | One-cycle strobe for `rx_byte_o` |

## Verification
The assertions assume the following about the inputs:
- the bit clock and frame sync are already synchronous to the core clock;
- each level of the bit clock is held for at least two core cycles;
- the bit clock is low while reset is held.

Under those conditions every change of the enable and every receive strobe can be traced to the bit-clock transition seen one core cycle earlier. The stimulus drives all inputs on the falling core-clock edge and holds each bit-clock level for four core cycles. It changes the straps only just before a frame's first rising edge, and each frame is 40 bit clocks long, which is more than either slot map needs.

// File: rtl/isdn_slot_pkg.sv
package isdn_slot_pkg;

    // Slot timing selected by the mode strap
    typedef enum logic {
        MODE_GCI = 1'b0,   // double-rate clock, 16-clock slots
        MODE_IDL = 1'b1    // single-rate clock, offset 8-clock slots
    } slot_mode_e;

endpackage

// File: rtl/islot_edge_timer.sv
module islot_edge_timer #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bclk_i,
    input  logic             fsync_i,
    output logic             rise_o,
    output logic             fall_o,
    output logic             start_o,
    output logic             active_o,
    output logic [CNT_W-1:0] idx_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic             bclk;
        logic             fs_prev;
        logic             active;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d   = tmr_q;
        rise_o  = bclk_i & ~tmr_q.bclk;
        fall_o  = ~bclk_i & tmr_q.bclk;
        start_o = rise_o & fsync_i & ~tmr_q.fs_prev;
        tmr_d.bclk = bclk_i;
        if (rise_o) begin
            tmr_d.fs_prev = fsync_i;
            if (start_o) begin
                tmr_d.cnt    = '0;
                tmr_d.active = 1'b1;
            end else if (tmr_q.active && tmr_q.cnt != CNT_MAX) begin
                tmr_d.cnt = tmr_q.cnt + 1'b1;
            end
        end
        // index of the edge being handled in this cycle
        idx_o    = rise_o ? tmr_d.cnt : tmr_q.cnt;
        active_o = tmr_q.active | start_o;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

endmodule

// File: rtl/islot_mode_qual.sv
module islot_mode_qual
    import isdn_slot_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       mode_strap_i,
    input  logic       chan_strap_i,
    output slot_mode_e mode_o,
    output logic       ok_o,
    output logic       b2_o
);

    typedef struct packed {
        slot_mode_e cand;
        logic       seen;
        slot_mode_e mode;
        logic       ok;
        logic       b2;
    } qual_t;

    qual_t qual_d, qual_q;

    always_comb begin
        qual_d = qual_q;
        if (start_i) begin
            qual_d.cand = slot_mode_e'(mode_strap_i);
            qual_d.seen = 1'b1;
            qual_d.b2   = chan_strap_i;
            if (qual_q.seen && qual_d.cand == qual_q.cand) begin
                qual_d.mode = qual_d.cand;
                qual_d.ok   = 1'b1;
            end else begin
                qual_d.ok   = 1'b0;
            end
        end
        // the settings of a new frame apply from its very first edge
        mode_o = start_i ? qual_d.mode : qual_q.mode;
        ok_o   = start_i ? qual_d.ok   : qual_q.ok;
        b2_o   = start_i ? qual_d.b2   : qual_q.b2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            qual_q <= '{cand: MODE_GCI, seen: 1'b0, mode: MODE_GCI, ok: 1'b0, b2: 1'b0};
        end else begin
            qual_q <= qual_d;
        end
    end

endmodule

// File: rtl/islot_engine.sv
module islot_engine
    import isdn_slot_pkg::*;
#(
    parameter int BYTE_W       = 8,
    parameter int CNT_W        = 6,
    parameter int IDL_B1_START = 1,
    parameter int IDL_B2_START = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rise_i,
    input  logic              fall_i,
    input  logic              start_i,
    input  logic              active_i,
    input  logic [CNT_W-1:0]  idx_i,
    input  slot_mode_e        mode_i,
    input  logic              ok_i,
    input  logic              b2_i,
    input  logic [BYTE_W-1:0] tx_byte_i,
    input  logic              rx_data_i,
    output logic              tx_data_o,
    output logic              tx_oe_o,
    output logic [BYTE_W-1:0] rx_byte_o,
    output logic              rx_valid_o
);

    localparam int IDX_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
    localparam logic [CNT_W-1:0] GCI_SPAN = CNT_W'(2 * BYTE_W);
    localparam logic [CNT_W-1:0] GCI_B2   = CNT_W'(2 * BYTE_W);
    localparam logic [CNT_W-1:0] IDL_SPAN = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] IDL_B1   = CNT_W'(IDL_B1_START);
    localparam logic [CNT_W-1:0] IDL_B2   = CNT_W'(IDL_B2_START);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    typedef struct packed {
        logic [BYTE_W-1:0] txb;
        logic              oe;
        logic              dout;
        logic [BYTE_W-1:0] rsh;
        logic [BYTE_W-1:0] rbyte;
        logic              rvalid;
    } eng_t;

    eng_t eng_d, eng_q;

    logic              gci;
    logic [CNT_W-1:0]  base;
    logic [CNT_W-1:0]  span;
    logic [CNT_W-1:0]  off;
    logic [CNT_W-1:0]  bitn;
    logic [IDX_W-1:0]  sel;
    logic              in_slot;
    logic              last_edge;
    logic [BYTE_W-1:0] tx_word;
    logic [BYTE_W-1:0] rx_next;

    always_comb begin
        gci       = (mode_i == MODE_GCI);
        base      = gci ? (b2_i ? GCI_B2 : '0) : (b2_i ? IDL_B2 : IDL_B1);
        span      = gci ? GCI_SPAN : IDL_SPAN;
        off       = idx_i - base;
        in_slot   = active_i && ok_i && (idx_i >= base) && (off < span);
        bitn      = gci ? (off >> 1) : off;
        sel       = IDX_W'(BYTE_W - 1) - bitn[IDX_W-1:0];
        last_edge = (off == span - 1'b1);
        tx_word   = start_i ? tx_byte_i : eng_q.txb;
        rx_next   = {eng_q.rsh[BYTE_W-2:0], rx_data_i};

        eng_d        = eng_q;
        eng_d.txb    = tx_word;
        eng_d.rvalid = 1'b0;

        if (rise_i) begin
            eng_d.oe   = in_slot;
            eng_d.dout = in_slot ? tx_word[sel] : 1'b0;
            // double rate: sample in the middle of each two-clock bit
            if (gci && in_slot && off[0]) begin
                eng_d.rsh = rx_next;
                if (bitn == LAST_BIT) begin
                    eng_d.rbyte  = rx_next;
                    eng_d.rvalid = 1'b1;
                end
            end
        end

        if (fall_i && in_slot) begin
            if (last_edge) begin
                eng_d.oe   = 1'b0;
                eng_d.dout = 1'b0;
            end
            if (!gci) begin
                eng_d.rsh = rx_next;
                if (bitn == LAST_BIT) begin
                    eng_d.rbyte  = rx_next;
                    eng_d.rvalid = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_q <= '0;
        end else begin
            eng_q <= eng_d;
        end
    end

    assign tx_data_o  = eng_q.dout;
    assign tx_oe_o    = eng_q.oe;
    assign rx_byte_o  = eng_q.rbyte;
    assign rx_valid_o = eng_q.rvalid;

endmodule

// File: rtl/isdn_bslot_port.sv
module isdn_bslot_port
    import isdn_slot_pkg::*;
#(
    parameter int BYTE_W       = 8,
    parameter int CNT_W        = 6,
    parameter int IDL_B1_START = 1,
    parameter int IDL_B2_START = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bclk_i,
    input  logic              fsync_i,
    input  logic              mode_strap_i,
    input  logic              chan_strap_i,
    input  logic [BYTE_W-1:0] tx_byte_i,
    input  logic              rx_data_i,
    output logic              tx_data_o,
    output logic              tx_oe_o,
    output logic [BYTE_W-1:0] rx_byte_o,
    output logic              rx_valid_o
);

    logic             edge_rise;
    logic             edge_fall;
    logic             frame_start;
    logic             frame_active;
    logic [CNT_W-1:0] edge_idx;
    slot_mode_e       cfg_mode;
    logic             cfg_ok;
    logic             cfg_b2;

    islot_edge_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .bclk_i   (bclk_i),
        .fsync_i  (fsync_i),
        .rise_o   (edge_rise),
        .fall_o   (edge_fall),
        .start_o  (frame_start),
        .active_o (frame_active),
        .idx_o    (edge_idx)
    );

    islot_mode_qual u_qual (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (frame_start),
        .mode_strap_i (mode_strap_i),
        .chan_strap_i (chan_strap_i),
        .mode_o       (cfg_mode),
        .ok_o         (cfg_ok),
        .b2_o         (cfg_b2)
    );

    islot_engine #(
        .BYTE_W       (BYTE_W),
        .CNT_W        (CNT_W),
        .IDL_B1_START (IDL_B1_START),
        .IDL_B2_START (IDL_B2_START)
    ) u_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .rise_i     (edge_rise),
        .fall_i     (edge_fall),
        .start_i    (frame_start),
        .active_i   (frame_active),
        .idx_i      (edge_idx),
        .mode_i     (cfg_mode),
        .ok_i       (cfg_ok),
        .b2_i       (cfg_b2),
        .tx_byte_i  (tx_byte_i),
        .rx_data_i  (rx_data_i),
        .tx_data_o  (tx_data_o),
        .tx_oe_o    (tx_oe_o),
        .rx_byte_o  (rx_byte_o),
        .rx_valid_o (rx_valid_o)
    );

endmodule

// File: rtl/isdn_bslot_port_chk.sv
module isdn_bslot_port_chk (
    input logic clk,
    input logic rst_n,
    input logic bclk_i,
    input logic tx_oe_o,
    input logic tx_data_o,
    input logic rx_valid_o,
    input logic cfg_ok
);

    // R8
    idle_data_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_oe_o |-> !tx_data_o);

    // R8
    oe_follows_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_oe_o != $past(tx_oe_o)) |-> ($past(bclk_i) != $past(bclk_i, 2)));

    // R9
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |=> !rx_valid_o);

    // R9
    strobe_after_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |-> ($past(bclk_i) != $past(bclk_i, 2)));

    // R2
    drive_needs_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_oe_o) |-> $past(cfg_ok));

endmodule

bind isdn_bslot_port isdn_bslot_port_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bclk_i     (bclk_i),
    .tx_oe_o    (tx_oe_o),
    .tx_data_o  (tx_data_o),
    .rx_valid_o (rx_valid_o),
    .cfg_ok     (cfg_ok)
);

// File: tb/isdn_bslot_port_tb.sv
`timescale 1ns/1ps
module isdn_bslot_port_tb;

    localparam int FRAME_LEN = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bclk_i = 1'b0;
    logic       fsync_i = 1'b0;
    logic       mode_strap_i = 1'b0;
    logic       chan_strap_i = 1'b0;
    logic [7:0] tx_byte_i = 8'h00;
    logic       rx_data_i = 1'b0;
    logic       tx_data_o;
    logic       tx_oe_o;
    logic [7:0] rx_byte_o;
    logic       rx_valid_o;

    int checks = 0;
    int fails  = 0;
    int rxv_cnt = 0;
    logic [7:0] rx_seen = 8'h00;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    isdn_bslot_port u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .bclk_i       (bclk_i),
        .fsync_i      (fsync_i),
        .mode_strap_i (mode_strap_i),
        .chan_strap_i (chan_strap_i),
        .tx_byte_i    (tx_byte_i),
        .rx_data_i    (rx_data_i),
        .tx_data_o    (tx_data_o),
        .tx_oe_o      (tx_oe_o),
        .rx_byte_o    (rx_byte_o),
        .rx_valid_o   (rx_valid_o)
    );

    // receive strobe monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (rx_valid_o) begin
            rxv_cnt <= rxv_cnt + 1;
            rx_seen <= rx_byte_o;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic int slot_base(input bit idl, input bit b2);
        if (idl) return b2 ? 11 : 1;
        return b2 ? 16 : 0;
    endfunction

    function automatic int slot_span(input bit idl);
        return idl ? 8 : 16;
    endfunction

    function automatic bit in_slot(input bit idl, input bit b2, input int k);
        int b = slot_base(idl, b2);
        return (k >= b) && (k < b + slot_span(idl));
    endfunction

    function automatic int bit_of(input bit idl, input bit b2, input int k);
        int o = k - slot_base(idl, b2);
        return idl ? o : o / 2;
    endfunction

    // One frame: qualified tells whether the mode should be in force
    task automatic run_frame(input bit idl, input bit b2, input logic [7:0] txb,
                             input logic [7:0] rxb, input bit qualified, input string tag);
        int  mism = 0;
        int  first_act = 0;
        int  first_exp = 0;
        bit  exp_oe;
        bit  exp_d;
        mode_strap_i = idl;
        chan_strap_i = b2;
        tx_byte_i    = txb;
        rxv_cnt      = 0;
        for (int k = 0; k < FRAME_LEN; k++) begin
            @(negedge clk);
            fsync_i = (k == 0);
            if (k == 5) tx_byte_i = ~txb;   // R10: late change must not be sent
            if (in_slot(idl, b2, k))
                rx_data_i = rxb[7 - bit_of(idl, b2, k)];
            else
                rx_data_i = k[0] ^ k[2];
            bclk_i = 1'b1;
            repeat (2) @(negedge clk);
            exp_oe = qualified && in_slot(idl, b2, k);
            exp_d  = exp_oe ? txb[7 - bit_of(idl, b2, k)] : 1'b0;
            if (tx_oe_o !== exp_oe || tx_data_o !== exp_d) begin
                if (mism == 0) begin
                    first_act = {k, 2'b0, tx_oe_o, tx_data_o};
                    first_exp = {k, 2'b0, exp_oe, exp_d};
                end
                mism++;
            end
            @(negedge clk);
            @(negedge clk);
            bclk_i = 1'b0;
            repeat (2) @(negedge clk);
            exp_oe = qualified && in_slot(idl, b2, k) &&
                     (k != slot_base(idl, b2) + slot_span(idl) - 1);
            exp_d  = exp_oe ? txb[7 - bit_of(idl, b2, k)] : 1'b0;
            if (tx_oe_o !== exp_oe || tx_data_o !== exp_d) begin
                if (mism == 0) begin
                    first_act = {k, 2'b1, tx_oe_o, tx_data_o};
                    first_exp = {k, 2'b1, exp_oe, exp_d};
                end
                mism++;
            end
            @(negedge clk);
        end
        check(mism == 0, {tag, " transmit slot"}, first_act, first_exp);
        check(rxv_cnt == (qualified ? 1 : 0), {tag, " R9 strobe count"}, rxv_cnt, qualified ? 1 : 0);
        if (qualified)
            check(rx_seen == rxb, {tag, " received byte"}, rx_seen, rxb);
    endtask

    task automatic test_reset();
        repeat (3) @(negedge clk);
        check(tx_oe_o == 1'b0 && tx_data_o == 1'b0, "R1 tx idle in reset", {tx_oe_o, tx_data_o}, 0);
        check(rx_valid_o == 1'b0 && rx_byte_o == 8'h00, "R1 rx idle in reset", {rx_valid_o, rx_byte_o}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(tx_oe_o == 1'b0 && rx_valid_o == 1'b0, "R1 idle after reset", {tx_oe_o, rx_valid_o}, 0);
    endtask

    task automatic test_gci();
        run_frame(1'b0, 1'b0, 8'hA5, 8'h3C, 1'b0, "R2 gci first frame unqualified");
        run_frame(1'b0, 1'b0, 8'hA5, 8'h3C, 1'b1, "R4 R5 R10 gci b1");
        run_frame(1'b0, 1'b1, 8'h96, 8'hE1, 1'b1, "R3 R4 R5 gci b2");
    endtask

    task automatic test_idl();
        run_frame(1'b1, 1'b0, 8'h5A, 8'hC3, 1'b0, "R2 idl change unqualified");
        run_frame(1'b1, 1'b0, 8'h5A, 8'hC3, 1'b1, "R6 R7 R8 idl b1");
        run_frame(1'b1, 1'b1, 8'h81, 8'h7E, 1'b1, "R3 R6 R7 idl b2");
    endtask

    task automatic test_glitch();
        run_frame(1'b0, 1'b1, 8'hFF, 8'h00, 1'b0, "R2 one-frame strap glitch");
        run_frame(1'b1, 1'b1, 8'h42, 8'hBD, 1'b0, "R2 strap back, not yet agreed");
        run_frame(1'b1, 1'b1, 8'h42, 8'hBD, 1'b1, "R2 R6 R7 idl b2 after glitch");
    endtask

    initial begin
        test_reset();
        test_gci();
        test_idl();
        test_glitch();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule